// File: doc/BRIEF.md
# Serial Parameter and Control Register Port

This block is a serial slave that gives an external controller read and write access to a 256-word parameter memory and to a small bank of control registers. It has four pins: an active-low latch (select) line, a bit clock, a serial data input, and a three-state serial data output. All three inputs pass through a two-flop synchronizer into the system clock domain. The block finds bit-clock edges there, so the bit clock can toggle all the time or stay idle between transactions.

A transaction opens when the latch line falls and closes when it rises. The first bit is a direction flag, followed by a ten-bit address, followed by the data. The address decides how much data follows. The parameter memory takes 24-bit words. The control registers take 16-bit words. A write is committed only when every data bit has arrived. On a read, the block drives the data word out on falling bit-clock edges, so the controller can sample it on rising edges. The low four bits of the first control register drive the format select of a neighbouring serial audio input block.

Top module: `spi_param_port`

## Requirements
- R1: After reset the output enable is low, every parameter word and control register reads as zero, and the format select output is 0.
- R2: A frame has the following bits, each sampled on a rising bit-clock edge while the latch is low. The first bit is the direction flag (1 = read, 0 = write). Next come address bits 9 down to 0. Then come the data bits, MSB first.
- R3: Addresses 0 to 255 carry 24 data bits. Addresses 256 to 1023 carry 16 data bits. A parameter write that supplies only 16 data bits does not commit, and a register write that supplies 16 bits does commit.
- R4: A full write to a parameter address stores all 24 bits, and a later read of that address returns the same 24 bits.
- R5: Control registers sit at addresses 256 to 259 and hold 16 bits each. A full write stores the value, and a read returns it.
- R6: On a read, the first data bit (MSB) is driven after the falling bit-clock edge that follows the eleventh rising edge. Each later falling edge presents the next bit.
- R7: The output enable (spi_dout_oe) is high only from the end of a read header until the latch rises. At all other times spi_dout is high-impedance and the enable is low.
- R8: If the latch rises before all data bits of a write have arrived, nothing is written.
- R9: Bit-clock edges after the last data bit of a write are ignored. The committed word is the first full one, and each frame makes at most one write.
- R10: Bits 3:0 of the register at address 256 drive fmt_sel. fmt_sel changes only through a write to that register.
- R11: Addresses 260 to 1023 read as zero. Writes to them change no parameter word and no control register.
- R12: Bit-clock edges that arrive while the latch is high are ignored, so a free-running bit clock and a gated bit clock give the same results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_latch_n | input | 1 | Transaction latch; low for the length of a frame |
| spi_sclk | input | 1 | Serial bit clock; free-running or gated |
| spi_din | input | 1 | Serial data in, sampled on rising bit-clock edges |
| spi_dout | output | 1 | Serial read data, three-stated when no read is active |
| spi_dout_oe | output | 1 | High while spi_dout is being driven |
| fmt_sel | output | 4 | Serial audio format select, from register 256 bits 3:0 |

## Verification
The bench targets frames whose length does not match the address space. Two cases matter most. A parameter write cut off after 16 data bits must leave memory unchanged. A design that takes its length from the wrong space would commit a wrong word there. A frame with trailing extra bits would instead corrupt the stored word or write it twice.

The bench also checks that bit-clock toggles outside the latch window are ignored. A design that counts them would misalign every later address. Read timing is checked bit by bit. A one-edge error in when the MSB is driven shows up as a shifted word. Unmapped addresses are checked too: both reads and writes to them must leave the real registers unchanged, so a design whose address decode aliased them would show up.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int ADDR_W   = 10;
  localparam int RAM_DEPTH = 256;
  localparam int RAM_AW   = $clog2(RAM_DEPTH);
  localparam int RAM_W    = 24;
  localparam int REG_W    = 16;
  localparam int FMT_W    = 4;
  localparam int HDR_BITS = 1 + ADDR_W;
  localparam int CNT_W    = $clog2(HDR_BITS + RAM_W + 1);

  // number of data bits carried by a frame at this address
  function automatic int data_len(input logic [ADDR_W-1:0] a);
    return (a < ADDR_W'(RAM_DEPTH)) ? RAM_W : REG_W;
  endfunction

  // total rising edges in a complete frame at this address
  function automatic logic [CNT_W-1:0] frame_len(input logic [ADDR_W-1:0] a);
    return CNT_W'(HDR_BITS + data_len(a));
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= IDLE;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame import spi_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sclk_s,
  input  logic              din_s,
  input  logic [RAM_W-1:0]  rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [RAM_W-1:0]  wr_data,
  output logic              dout_bit,
  output logic              dout_oe
);
  logic              sclk_d;
  logic [CNT_W-1:0]  bit_cnt;
  logic [ADDR_W-1:0] hdr_q;
  logic              rw_q;
  logic [ADDR_W-1:0] addr_q;
  logic [RAM_W-2:0]  dat_q;
  logic [RAM_W-1:0]  tx_q;

  // named events for assertions
  logic              sclk_rise, sclk_fall;
  logic [HDR_BITS-1:0] hdr_next;
  logic [RAM_W-1:0]  dat_next;
  logic [CNT_W-1:0]  frame_total;
  logic              in_hdr, hdr_last, data_bit, wr_fire, rd_load;

  assign sclk_rise   = sclk_s & ~sclk_d;
  assign sclk_fall   = ~sclk_s & sclk_d;
  assign hdr_next    = {hdr_q, din_s};
  assign dat_next    = {dat_q, din_s};
  assign frame_total = frame_len(addr_q);
  assign in_hdr      = bit_cnt < CNT_W'(HDR_BITS);
  assign hdr_last    = cs_act & sclk_rise & (bit_cnt == CNT_W'(HDR_BITS - 1));
  assign data_bit    = cs_act & sclk_rise & ~in_hdr & (bit_cnt < frame_total);
  assign wr_fire     = data_bit & ~rw_q & (bit_cnt == frame_total - 1'b1);
  assign rd_load     = hdr_last & hdr_next[HDR_BITS-1];
  assign rd_addr     = hdr_next[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      bit_cnt  <= '0;
      hdr_q    <= '0;
      rw_q     <= 1'b0;
      addr_q   <= '0;
      dat_q    <= '0;
      tx_q     <= '0;
      dout_bit <= 1'b0;
      dout_oe  <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      sclk_d <= sclk_s;
      wr_en  <= wr_fire;
      if (wr_fire) begin
        wr_addr <= addr_q;
        wr_data <= dat_next;
      end
      if (!cs_act) begin
        bit_cnt <= '0;
        dat_q   <= '0;
        dout_oe <= 1'b0;
      end else begin
        if (sclk_rise && in_hdr) begin
          hdr_q   <= hdr_next[ADDR_W-1:0];
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (data_bit) begin
          dat_q   <= dat_next[RAM_W-2:0];
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (hdr_last) begin
          rw_q   <= hdr_next[HDR_BITS-1];
          addr_q <= hdr_next[ADDR_W-1:0];
        end
        if (rd_load) begin
          tx_q    <= (data_len(rd_addr) == RAM_W) ? rd_data
                                                  : {rd_data[REG_W-1:0], {(RAM_W-REG_W){1'b0}}};
          dout_oe <= 1'b1;
        end else if (sclk_fall && dout_oe) begin
          dout_bit <= tx_q[RAM_W-1];
          tx_q     <= {tx_q[RAM_W-2:0], 1'b0};
        end
      end
    end
  end

  AST_OE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !dout_oe);                                              // R7
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> rw_q);                                                  // R7
  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);                                                  // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(HDR_BITS + RAM_W));                               // R3
  AST_NO_WRITE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && dout_oe));                                               // R7
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile import spi_pkg::*; #(
  parameter int NUM_CTRL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [RAM_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [RAM_W-1:0]  rd_data,
  output logic [FMT_W-1:0]  fmt_out
);
  localparam int CTRL_AW = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1;
  localparam logic [ADDR_W-1:0] RAM_TOP = ADDR_W'(RAM_DEPTH);
  localparam logic [ADDR_W-1:0] CTRL_N  = ADDR_W'(NUM_CTRL);

  logic [RAM_W-1:0] ram  [RAM_DEPTH];
  logic [REG_W-1:0] ctrl [NUM_CTRL];

  logic [ADDR_W-1:0] wr_off, rd_off;
  logic wr_ram, wr_ctrl;

  assign wr_off  = wr_addr - RAM_TOP;
  assign rd_off  = rd_addr - RAM_TOP;
  assign wr_ram  = wr_en & (wr_addr < RAM_TOP);
  assign wr_ctrl = wr_en & (wr_addr >= RAM_TOP) & (wr_off < CTRL_N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= '0;
      for (int i = 0; i < NUM_CTRL; i++) ctrl[i] <= '0;
    end else begin
      if (wr_ram)  ram[wr_addr[RAM_AW-1:0]]   <= wr_data;
      if (wr_ctrl) ctrl[wr_off[CTRL_AW-1:0]]  <= wr_data[REG_W-1:0];
    end
  end

  always_comb begin
    if (rd_addr < RAM_TOP)
      rd_data = ram[rd_addr[RAM_AW-1:0]];
    else if (rd_off < CTRL_N)
      rd_data = {{(RAM_W-REG_W){1'b0}}, ctrl[rd_off[CTRL_AW-1:0]]};
    else
      rd_data = '0;
  end

  assign fmt_out = ctrl[0][FMT_W-1:0];

  AST_FMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(fmt_out));                                     // R10
  AST_WRITE_ONE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ram && wr_ctrl));                                              // R11
endmodule

// File: rtl/spi_param_port.sv
module spi_param_port import spi_pkg::*; #(
  parameter int NUM_CTRL    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_latch_n,
  input  logic             spi_sclk,
  input  logic             spi_din,
  output wire              spi_dout,
  output logic             spi_dout_oe,
  output logic [FMT_W-1:0] fmt_sel
);
  logic [2:0]        pins_s;
  logic              cs_act;
  logic [RAM_W-1:0]  rd_data;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [RAM_W-1:0]  wr_data;
  logic              dout_bit;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .IDLE(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_latch_n, spi_sclk, spi_din}),
    .q(pins_s)
  );

  assign cs_act = ~pins_s[2];

  spi_frame u_frame (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
    .sclk_s(pins_s[1]), .din_s(pins_s[0]),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dout_bit(dout_bit), .dout_oe(spi_dout_oe)
  );

  spi_regfile #(.NUM_CTRL(NUM_CTRL)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .fmt_out(fmt_sel)
  );

  assign spi_dout = spi_dout_oe ? dout_bit : 1'bz;
endmodule

// File: tb/tb_spi_param_port.sv
module tb_spi_param_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_latch_n = 1'b1;
  logic spi_sclk = 1'b0;
  logic spi_din = 1'b0;
  wire  spi_dout;
  logic spi_dout_oe;
  logic [3:0] fmt_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [23:0] m_ram [256];
  logic [15:0] m_ctrl [4];

  always #4 clk = ~clk;

  spi_param_port dut (
    .clk(clk), .rst_n(rst_n), .spi_latch_n(spi_latch_n), .spi_sclk(spi_sclk),
    .spi_din(spi_din), .spi_dout(spi_dout), .spi_dout_oe(spi_dout_oe), .fmt_sel(fmt_sel)
  );

  task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int dlen(input logic [9:0] a);
    return (a < 10'd256) ? 24 : 16;
  endfunction

  function automatic logic [23:0] exp_rd(input logic [9:0] a);
    if (a < 10'd256) return m_ram[a[7:0]];
    if (a < 10'd260) return {8'h0, m_ctrl[a - 10'd256]};
    return 24'h0;
  endfunction

  function automatic logic frame_bit(input bit rw, input logic [9:0] a, input logic [23:0] wd, input int i);
    int dl = dlen(a);
    if (i == 0) return rw;
    if (i <= 10) return a[10 - i];
    if (i < 11 + dl) return wd[dl - 1 - (i - 11)];
    return 1'b1;
  endfunction

  task automatic idle_clocks(input bit free);
    if (free) begin
      repeat (3) begin
        spi_din = 1'($urandom);
        #64 spi_sclk = 1'b1;
        #64 spi_sclk = 1'b0;
      end
    end else #64;
  endtask

  // one transaction of nbits rising edges
  task automatic xfer(input bit rw, input logic [9:0] a, input logic [23:0] wd, input int nbits,
                      input bit free, output logic [23:0] rd, output bit oe_bad);
    int dl = dlen(a);
    rd = '0;
    oe_bad = 0;
    idle_clocks(free);
    #24 spi_latch_n = 1'b0;
    #64;
    if (spi_dout_oe) oe_bad = 1;
    for (int i = 0; i < nbits; i++) begin
      spi_din = frame_bit(rw, a, wd, i);
      #64 spi_sclk = 1'b1;
      if (rw && i >= 11 && i < 11 + dl) rd = {rd[22:0], spi_dout};
      if (i >= 11 && spi_dout_oe != rw) oe_bad = 1;
      if (i < 11 && spi_dout_oe) oe_bad = 1;
      #64 spi_sclk = 1'b0;
    end
    #64 spi_latch_n = 1'b1;
    idle_clocks(free);
    #200;
    if (spi_dout_oe) oe_bad = 1;
  endtask

  task automatic do_write(input logic [9:0] a, input logic [23:0] wd, input int nbits, input bit free);
    logic [23:0] rd;
    bit ob;
    xfer(1'b0, a, wd, nbits, free, rd, ob);
    chk(!ob, "R7 oe during write", {23'h0, ob}, 24'h0);
    if (nbits >= 11 + dlen(a)) begin
      if (a < 10'd256) m_ram[a[7:0]] = wd;
      else if (a < 10'd260) m_ctrl[a - 10'd256] = wd[15:0];
    end
  endtask

  task automatic do_read(input logic [9:0] a, input bit free, input string req);
    logic [23:0] rd;
    bit ob;
    xfer(1'b1, a, 24'h0, 11 + dlen(a), free, rd, ob);
    chk(!ob, "R7 oe window on read", {23'h0, ob}, 24'h0);
    chk(rd == exp_rd(a), req, rd, exp_rd(a));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_ram[i] = '0;
    for (int i = 0; i < 4; i++) m_ctrl[i] = '0;
    #40 rst_n = 1'b1;
    @(negedge clk);
    #64;
    // R1 reset state
    chk(spi_dout_oe == 1'b0, "R1 oe after reset", {23'h0, spi_dout_oe}, 24'h0);
    chk(fmt_sel == 4'h0, "R1 fmt after reset", {20'h0, fmt_sel}, 24'h0);
    do_read(10'd0, 0, "R1 ram[0] reset");
    do_read(10'd255, 0, "R1 ram[255] reset");
    do_read(10'd256, 0, "R1 reg256 reset");
    // R2 R4 R6 parameter write and bit-exact read
    do_write(10'd5, 24'hA5C3E1, 35, 0);
    do_read(10'd5, 0, "R4 R6 R2 ram[5] readback");
    do_write(10'd200, 24'h800001, 35, 0);
    do_read(10'd200, 0, "R4 R6 ram[200] edge bits");
    // R5 control register
    do_write(10'd257, 24'hFFBEEF, 27, 0);
    do_read(10'd257, 0, "R5 reg257 readback");
    // R10 format select
    do_write(10'd256, 24'h001239, 27, 0);
    chk(fmt_sel == 4'h9, "R10 fmt_sel from reg256", {20'h0, fmt_sel}, 24'h9);
    do_write(10'd258, 24'h00000F, 27, 0);
    chk(fmt_sel == 4'h9, "R10 fmt_sel unchanged by reg258", {20'h0, fmt_sel}, 24'h9);
    // R8 early end
    do_write(10'd5, 24'h123456, 20, 0);
    do_read(10'd5, 0, "R8 ram[5] after short write");
    do_write(10'd257, 24'h001111, 26, 0);
    do_read(10'd257, 0, "R8 reg257 after short write");
    // R3 length by space: 16 data bits commit only to registers
    do_write(10'd9, 24'h00ABCD, 27, 0);
    do_read(10'd9, 0, "R3 ram[9] needs 24 bits");
    do_write(10'd259, 24'h00ABCD, 27, 0);
    do_read(10'd259, 0, "R3 reg259 takes 16 bits");
    // R9 trailing bits
    do_write(10'd7, 24'h5A5A5A, 45, 0);
    do_read(10'd7, 0, "R9 ram[7] trailing bits ignored");
    do_write(10'd258, 24'h00C0DE, 33, 0);
    do_read(10'd258, 0, "R9 reg258 trailing bits ignored");
    // R11 unmapped
    do_write(10'd600, 24'h001234, 27, 0);
    do_write(10'd260, 24'h00FFFF, 27, 0);
    do_read(10'd600, 0, "R11 addr600 reads zero");
    do_read(10'd260, 0, "R11 addr260 reads zero");
    for (int k = 256; k < 260; k++) do_read(10'(k), 0, "R11 registers untouched");
    chk(fmt_sel == 4'h9, "R11 fmt_sel untouched", {20'h0, fmt_sel}, 24'h9);
    // R12 free-running clock
    do_write(10'd33, 24'h0F0F0F, 35, 1);
    do_read(10'd33, 1, "R12 free-running ram[33]");
    // constrained random mix
    void'($urandom(32'd20240611));
    for (int n = 0; n < 60; n++) begin
      logic [9:0] a;
      int sel = int'($urandom % 4);
      bit rw = 1'($urandom);
      bit fr = 1'($urandom);
      logic [23:0] wd = 24'($urandom);
      int nb;
      if (sel < 2)       a = 10'($urandom % 256);
      else if (sel == 2) a = 10'(256 + $urandom % 4);
      else               a = 10'(260 + $urandom % 764);
      nb = 11 + dlen(a);
      if ($urandom % 8 == 0) nb = 1 + int'($urandom % (10 + dlen(a)));
      if (rw) do_read(a, fr, "R2 R12 random read");
      else    do_write(a, wd, nb, fr);
    end
    for (int k = 256; k < 260; k++) do_read(10'(k), 0, "R5 final register state");
    chk(fmt_sel == m_ctrl[0][3:0], "R10 final fmt_sel", {20'h0, fmt_sel}, {20'h0, m_ctrl[0][3:0]});
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule